// File: doc/BRIEF.md
# Audio Link Frame Serializer

This block is the transmit half of the controller side of a codec serial link. It runs on the bit clock and produces one frame every 256 bit clocks. Each frame is a 16-bit tag slot followed by twelve 20-bit slots. The block also drives the frame sync strobe that marks where each frame begins.

The parallel inputs are:
- a codec register command: a read/write flag, a register index and write data;
- left and right playback samples, with a sample-width setting and a mono flag;
- one valid flag for each of the twelve slots.

At the start of every frame the block formats all slots at once and stores the whole frame in a shadow register. It then shifts the frame out MSB first. Inputs may therefore change at any time without corrupting the frame already in flight.

Top module: `alink_serializer`

## Requirements
- R1: While `rst_n` is low, `sync` and `sdata` are 0. The first edge after release raises `sync`, and the first tag bit appears on the following edge.
- R2: Frames repeat every 256 bit clocks. `sync` is high for 16 bit clocks: on the last bit of the previous frame and on tag bits 15 to 1 of the new frame. Outputs change only on the rising edge of `bclk`.
- R3: The tag slot is sent first, MSB first. Tag bit 15 is 1 when at least one slot valid flag is set. Tag bit 14−k carries the valid flag of slot k+1, for k = 0 to 11 (`slot_valid[k]`). Tag bits 2:0 are 0.
- R4: Command slot (slot 1, transmitted MSB first):
  - bit 19 is `cmd_rd` (1 = read, 0 = write);
  - bits 18:12 hold the register index with its LSB forced to 0, so an odd index addresses the even register below it;
  - bits 11:0 are 0.
- R5: Slot 2 carries `cmd_wdata` in bits 19:4, and bits 3:0 are 0. When `cmd_rd` is 1, all 20 bits of slot 2 are 0.
- R6: Samples arrive right-justified in their 20-bit input.
  - A width w from 1 to 20 places input bits w−1:0 in slot bits 19:20−w, with bit w−1 first. All lower slot bits are 0.
  - Input bits above w−1 are ignored.
  - A width of 0 or above 20 means 20.
- R7: When `mono` is 1, slot 4 carries the formatted left sample, exactly as slot 3 does, and `pcm_right` is ignored.
- R8: A slot whose valid flag is 0 is sent as twenty 0 bits. Slots 5 to 12 are always sent as 0, whatever their flags.
- R9: All inputs are sampled on the edge that starts tag bit 15. Input changes at any other time affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rd | input | 1 | Command type, 1 = read, 0 = write |
| cmd_idx | input | 7 | Codec register index |
| cmd_wdata | input | 16 | Register write data |
| pcm_left | input | 20 | Left sample, right-justified |
| pcm_right | input | 20 | Right sample, right-justified |
| pcm_width | input | 5 | Sample width in bits (0 or above 20 means 20) |
| mono | input | 1 | Send the left sample in both playback slots |
| slot_valid | input | 12 | Valid flag per slot; bit 0 is slot 1 |
| sync | output | 1 | Frame sync strobe |
| sdata | output | 1 | Serial frame data |

## Verification
The checker locks onto the serial stream alone and then checks on every cycle:
- the position of the sync window within each frame;
- the zero pad bits of the tag;
- the agreement of tag bit 15 with the slot flags it has just received;
- the reserved bits of both command slots;
- the all-zero content of slots flagged invalid and of slots 5 to 12.

The checker cannot see the inputs. Sample justification, width clamping, mono duplication, the read/write dependence of slot 2 and frame-start sampling of the inputs are shown only by the bench. The bench compares every bit against a frame it builds from the inputs it applied.

// File: rtl/alink_pkg.sv
package alink_pkg;
   // Default frame geometry of the link
   localparam int unsigned ALINK_SLOT_W    = 20;
   localparam int unsigned ALINK_TAG_W     = 16;
   localparam int unsigned ALINK_NUM_SLOTS = 12;
   localparam int unsigned ALINK_IDX_W     = 7;
   localparam int unsigned ALINK_DATA_W    = 16;
   localparam int unsigned ALINK_WID_W     = 5;

   // Role of each slot within the frame (slot number minus one)
   typedef enum logic [1:0] {
      SLOT_CMD_ADDR = 2'd0,
      SLOT_CMD_DATA = 2'd1,
      SLOT_PCM      = 2'd2,
      SLOT_SPARE    = 2'd3
   } slot_role_e;

   function automatic slot_role_e role_of(input int unsigned slot_ix);
      if (slot_ix == 0)      return SLOT_CMD_ADDR;
      else if (slot_ix == 1) return SLOT_CMD_DATA;
      else if (slot_ix < 4)  return SLOT_PCM;
      else                   return SLOT_SPARE;
   endfunction
endpackage

// File: rtl/alink_slot_fmt.sv
// Justifies a right-aligned sample of programmable width to the top of a slot
module alink_slot_fmt #(
   parameter int unsigned SLOT_W = alink_pkg::ALINK_SLOT_W,
   parameter int unsigned WID_W  = alink_pkg::ALINK_WID_W
) (
   input  logic [SLOT_W-1:0] sample,
   input  logic [WID_W-1:0]  width,
   input  logic              enable,
   output logic [SLOT_W-1:0] slot
);
   localparam logic [WID_W-1:0] FULL_W = WID_W'(SLOT_W);

   logic [WID_W-1:0] eff_w;
   logic [WID_W-1:0] shamt;

   always_comb begin
      if (width == '0 || width > FULL_W) eff_w = FULL_W;
      else                               eff_w = width;
      shamt = FULL_W - eff_w;
      // left shift pushes stray upper bits out and zero-fills the tail
      slot  = enable ? (sample << shamt) : '0;
   end
endmodule

// File: rtl/alink_frame_build.sv
// Assembles the complete frame image (tag plus all slots) from the inputs
module alink_frame_build #(
   parameter int unsigned SLOT_W    = alink_pkg::ALINK_SLOT_W,
   parameter int unsigned TAG_W     = alink_pkg::ALINK_TAG_W,
   parameter int unsigned NUM_SLOTS = alink_pkg::ALINK_NUM_SLOTS,
   parameter int unsigned IDX_W     = alink_pkg::ALINK_IDX_W,
   parameter int unsigned DATA_W    = alink_pkg::ALINK_DATA_W,
   parameter int unsigned WID_W     = alink_pkg::ALINK_WID_W,
   localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W
) (
   input  logic                  cmd_rd,
   input  logic [IDX_W-1:0]      cmd_idx,
   input  logic [DATA_W-1:0]     cmd_wdata,
   input  logic [SLOT_W-1:0]     pcm_left,
   input  logic [SLOT_W-1:0]     pcm_right,
   input  logic [WID_W-1:0]      pcm_width,
   input  logic                  mono,
   input  logic [NUM_SLOTS-1:0]  slot_valid,
   output logic [FRAME_BITS-1:0] frame
);
   import alink_pkg::*;

   logic [TAG_W-1:0]  tag;
   logic [SLOT_W-1:0] addr_slot;
   logic [SLOT_W-1:0] data_slot;
   logic [SLOT_W-1:0] left_slot;
   logic [SLOT_W-1:0] right_slot;
   logic [SLOT_W-1:0] right_src;

   // Tag: frame-valid flag, one flag per slot, zero pad
   always_comb begin
      tag = '0;
      tag[TAG_W-1] = |slot_valid;
      for (int k = 0; k < int'(NUM_SLOTS); k++) begin
         tag[TAG_W-2-k] = slot_valid[k];
      end
   end

   // Command address slot; index LSB cleared to stay on an even register
   always_comb begin
      addr_slot = '0;
      if (slot_valid[0]) begin
         addr_slot[SLOT_W-1]          = cmd_rd;
         addr_slot[SLOT_W-2 -: IDX_W] = {cmd_idx[IDX_W-1:1], 1'b0};
      end
   end

   // Command data slot, empty on reads
   always_comb begin
      data_slot = '0;
      if (slot_valid[1] && !cmd_rd) begin
         data_slot[SLOT_W-1 -: DATA_W] = cmd_wdata;
      end
   end

   assign right_src = mono ? pcm_left : pcm_right;

   alink_slot_fmt #(.SLOT_W(SLOT_W), .WID_W(WID_W)) i_fmt_left (
      .sample (pcm_left),
      .width  (pcm_width),
      .enable (slot_valid[2]),
      .slot   (left_slot)
   );

   alink_slot_fmt #(.SLOT_W(SLOT_W), .WID_W(WID_W)) i_fmt_right (
      .sample (right_src),
      .width  (pcm_width),
      .enable (slot_valid[3]),
      .slot   (right_slot)
   );

   assign frame[FRAME_BITS-1 -: TAG_W] = tag;

   // Place each slot by its role
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      localparam int unsigned TOP = FRAME_BITS - TAG_W - 1 - k * SLOT_W;
      if (role_of(k) == SLOT_CMD_ADDR) begin : g_addr
         assign frame[TOP -: SLOT_W] = addr_slot;
      end else if (role_of(k) == SLOT_CMD_DATA) begin : g_data
         assign frame[TOP -: SLOT_W] = data_slot;
      end else if (role_of(k) == SLOT_PCM && k == 2) begin : g_left
         assign frame[TOP -: SLOT_W] = left_slot;
      end else if (role_of(k) == SLOT_PCM) begin : g_right
         assign frame[TOP -: SLOT_W] = right_slot;
      end else begin : g_spare
         assign frame[TOP -: SLOT_W] = '0;
      end
   end
endmodule

// File: rtl/alink_bit_timer.sv
// Bit position counter and look-ahead sync decode
module alink_bit_timer #(
   parameter int unsigned FRAME_BITS = 256,
   parameter int unsigned SYNC_LEN   = 16,
   localparam int unsigned CNT_W     = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] pos_next,
   output logic             frame_start,
   output logic             sync_next
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN - 1);

   logic [CNT_W-1:0] pos_q;

   always_comb begin
      pos_next    = (pos_q == LAST) ? '0 : pos_q + 1'b1;
      frame_start = (pos_next == '0);
      sync_next   = (pos_next == LAST) || (pos_next < SYNC_END);
   end

   // Reset parks two bits before a frame so the first frame gets a full sync
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= CNT_W'(FRAME_BITS - 2);
      else        pos_q <= pos_next;
   end
endmodule

// File: rtl/alink_serializer.sv
module alink_serializer #(
   parameter int unsigned SLOT_W    = alink_pkg::ALINK_SLOT_W,
   parameter int unsigned TAG_W     = alink_pkg::ALINK_TAG_W,
   parameter int unsigned NUM_SLOTS = alink_pkg::ALINK_NUM_SLOTS,
   parameter int unsigned IDX_W     = alink_pkg::ALINK_IDX_W,
   parameter int unsigned DATA_W    = alink_pkg::ALINK_DATA_W,
   parameter int unsigned WID_W     = alink_pkg::ALINK_WID_W,
   parameter int unsigned SYNC_LEN  = alink_pkg::ALINK_TAG_W
) (
   input  logic                 bclk,
   input  logic                 rst_n,
   input  logic                 cmd_rd,
   input  logic [IDX_W-1:0]     cmd_idx,
   input  logic [DATA_W-1:0]    cmd_wdata,
   input  logic [SLOT_W-1:0]    pcm_left,
   input  logic [SLOT_W-1:0]    pcm_right,
   input  logic [WID_W-1:0]     pcm_width,
   input  logic                 mono,
   input  logic [NUM_SLOTS-1:0] slot_valid,
   output logic                 sync,
   output logic                 sdata
);
   localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

   // Elaboration-time parameter checks
   if (NUM_SLOTS < 4)
      $error("alink_serializer: NUM_SLOTS must cover command and both PCM slots");
   if (TAG_W < NUM_SLOTS + 1)
      $error("alink_serializer: TAG_W too small for the slot flags");
   if (SLOT_W < IDX_W + 1 || SLOT_W < DATA_W)
      $error("alink_serializer: SLOT_W too small for the command fields");
   if ((1 << WID_W) <= SLOT_W)
      $error("alink_serializer: WID_W cannot express a full-width sample");
   if (SYNC_LEN < 2 || SYNC_LEN > FRAME_BITS - 1)
      $error("alink_serializer: SYNC_LEN out of range");

   logic [FRAME_BITS-1:0] frame_fmt;
   logic [FRAME_BITS-1:0] shadow_q;
   logic [CNT_W-1:0]      pos_next;
   logic                  frame_start;
   logic                  sync_next;

   alink_frame_build #(
      .SLOT_W(SLOT_W), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS),
      .IDX_W(IDX_W), .DATA_W(DATA_W), .WID_W(WID_W)
   ) i_build (
      .cmd_rd     (cmd_rd),
      .cmd_idx    (cmd_idx),
      .cmd_wdata  (cmd_wdata),
      .pcm_left   (pcm_left),
      .pcm_right  (pcm_right),
      .pcm_width  (pcm_width),
      .mono       (mono),
      .slot_valid (slot_valid),
      .frame      (frame_fmt)
   );

   alink_bit_timer #(.FRAME_BITS(FRAME_BITS), .SYNC_LEN(SYNC_LEN)) i_timer (
      .clk         (bclk),
      .rst_n       (rst_n),
      .pos_next    (pos_next),
      .frame_start (frame_start),
      .sync_next   (sync_next)
   );

   // Shadow shift register: loaded at frame start, shifted out MSB first
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         sdata    <= 1'b0;
         sync     <= 1'b0;
      end else begin
         sync <= sync_next;
         if (frame_start) begin
            sdata    <= frame_fmt[FRAME_BITS-1];
            shadow_q <= {frame_fmt[FRAME_BITS-2:0], 1'b0};
         end else begin
            sdata    <= shadow_q[FRAME_BITS-1];
            shadow_q <= {shadow_q[FRAME_BITS-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/alink_serializer_chk.sv
// Stream-level checker: locks onto the sync strobe and checks the serial output
module alink_serializer_chk #(
   parameter int unsigned SLOT_W    = 20,
   parameter int unsigned TAG_W     = 16,
   parameter int unsigned NUM_SLOTS = 12,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SYNC_LEN  = 16
) (
   input logic clk,
   input logic rst_n,
   input logic sync,
   input logic sdata
);
   localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int unsigned PW = $clog2(FRAME_BITS);

   logic          sync_d;
   logic          locked;
   logic [PW-1:0] pos;
   logic [TAG_W-1:0] tagcap;
   int            rel;
   int            slot_ix;
   int            bit_ix;
   logic          in_slots;
   logic          flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d <= 1'b0;
         locked <= 1'b0;
         pos    <= '0;
         tagcap <= '0;
      end else begin
         sync_d <= sync;
         if (sync && !sync_d) begin
            pos    <= '0;
            locked <= 1'b1;
         end else if (pos == PW'(FRAME_BITS - 1)) begin
            pos <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
         if (locked && int'(pos) < int'(TAG_W)) tagcap[TAG_W-1-int'(pos)] <= sdata;
      end
   end

   always_comb begin
      rel      = int'(pos) - int'(TAG_W);
      in_slots = locked && (rel >= 0);
      slot_ix  = (rel >= 0) ? rel / int'(SLOT_W) : 0;
      bit_ix   = (rel >= 0) ? int'(SLOT_W) - 1 - (rel % int'(SLOT_W)) : 0;
      flag     = tagcap[TAG_W-2-slot_ix];
   end

   AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (sync == ((int'(pos) == int'(FRAME_BITS) - 1) || (int'(pos) < int'(SYNC_LEN) - 1)))); // R2

   AST_TAG_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && int'(pos) > int'(NUM_SLOTS) && int'(pos) < int'(TAG_W)) |-> !sdata); // R3

   AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && int'(pos) == int'(TAG_W)) |-> (tagcap[TAG_W-1] == |tagcap[TAG_W-2 -: NUM_SLOTS])); // R3

   AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_slots && slot_ix == 0 && bit_ix <= int'(SLOT_W) - 1 - int'(IDX_W)) |-> !sdata); // R4

   AST_DATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_slots && slot_ix == 1 && bit_ix < int'(SLOT_W) - int'(DATA_W)) |-> !sdata); // R5

   AST_INVALID_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_slots && !flag) |-> !sdata); // R8

   AST_SPARE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_slots && slot_ix >= 4) |-> !sdata); // R8
endmodule

bind alink_serializer alink_serializer_chk #(
   .SLOT_W(SLOT_W), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS),
   .IDX_W(IDX_W), .DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN)
) i_chk (
   .clk   (bclk),
   .rst_n (rst_n),
   .sync  (sync),
   .sdata (sdata)
);

// File: tb/test_alink_serializer.sv
`timescale 1ns/1ps
module test_alink_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_rd = 1'b0;
   logic [6:0]  cmd_idx = '0;
   logic [15:0] cmd_wdata = '0;
   logic [19:0] pcm_left = '0;
   logic [19:0] pcm_right = '0;
   logic [4:0]  pcm_width = 5'd20;
   logic        mono = 1'b0;
   logic [11:0] slot_valid = '0;
   logic        sync;
   logic        sdata;

   int checks = 0;
   int errors = 0;
   string scen_req = "";

   always #2 clk = ~clk; // 250 MHz

   alink_serializer i_alink_serializer (
      .bclk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_idx(cmd_idx),
      .cmd_wdata(cmd_wdata), .pcm_left(pcm_left), .pcm_right(pcm_right),
      .pcm_width(pcm_width), .mono(mono), .slot_valid(slot_valid),
      .sync(sync), .sdata(sdata)
   );

   // ---------------- reference model ----------------
   bit q[$];
   int mpos = 254;
   int frames = 0;
   bit e_sync = 0;
   bit e_sd = 0;

   function automatic bit [19:0] justify(input bit [19:0] s, input int wreq);
      bit [19:0] v = '0;
      int w = (wreq == 0 || wreq > 20) ? 20 : wreq;
      for (int b = 0; b < w; b++) v[19 - b] = s[w - 1 - b];
      return v;
   endfunction

   task automatic push20(input bit [19:0] v);
      for (int b = 19; b >= 0; b--) q.push_back(v[b]);
   endtask

   task automatic build_frame();
      bit [19:0] v;
      q.delete();
      q.push_back(slot_valid != 0);
      for (int s = 0; s < 12; s++) q.push_back(slot_valid[s]);
      for (int b = 0; b < 3; b++) q.push_back(1'b0);
      v = '0;
      if (slot_valid[0]) begin
         v[19] = cmd_rd;
         v[18:12] = cmd_idx & 7'h7E;
      end
      push20(v);
      v = '0;
      if (slot_valid[1] && !cmd_rd) v = {cmd_wdata, 4'h0};
      push20(v);
      push20(slot_valid[2] ? justify(pcm_left, int'(pcm_width)) : 20'h0);
      push20(slot_valid[3] ? justify(mono ? pcm_left : pcm_right, int'(pcm_width)) : 20'h0);
      for (int s = 4; s < 12; s++) push20(20'h0);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mpos = 254; q.delete(); e_sync = 0; e_sd = 0; frames = 0;
      end else begin
         mpos = (mpos + 1) % 256;
         if (mpos == 0) begin build_frame(); frames++; end
         e_sd = (q.size() != 0) ? q.pop_front() : 1'b0;
         e_sync = (mpos == 255) || (mpos < 15);
      end
   end

   function automatic string req_of(input int p);
      if (scen_req != "") return scen_req;
      if (frames == 0) return "R1";
      if (p < 16) return "R3";
      if (p < 36) return "R4";
      if (p < 56) return "R5";
      if (p < 76) return "R6";
      if (p < 96) return mono ? "R7" : "R6";
      return "R8";
   endfunction

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         checks++;
         if (sync !== 1'b0 || sdata !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: sync=%b sdata=%b expected 0 0", sync, sdata);
         end
      end else begin
         checks++;
         if (sync !== e_sync) begin
            errors++;
            $display("FAIL %s sync at pos %0d: got %b expected %b",
                     (frames == 0) ? "R1" : "R2", mpos, sync, e_sync);
         end
         checks++;
         if (sdata !== e_sd) begin
            errors++;
            $display("FAIL %s sdata at pos %0d: got %b expected %b", req_of(mpos), mpos, sdata, e_sd);
         end
      end
   end

   task automatic run_frames(input int n);
      repeat (n * 256) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;                         // R1: sync rises next edge
      // R4 R5 R6: write command, full width stereo, all slots flagged
      cmd_idx = 7'h2C; cmd_wdata = 16'hA5C3; pcm_left = 20'hABCDE; pcm_right = 20'h12345;
      slot_valid = 12'hFFF;
      run_frames(2);
      // R4 R5: read with odd index, write data must be dropped
      cmd_rd = 1'b1; cmd_idx = 7'h13; cmd_wdata = 16'hFFFF;
      run_frames(1);
      // R6: 8-bit samples with stray upper bits
      cmd_rd = 1'b0; pcm_width = 5'd8; pcm_left = 20'hFF0A5; pcm_right = 20'h3C05A;
      run_frames(1);
      // R6: width 0 and 31 clamp to 20, width 1
      pcm_width = 5'd0;  run_frames(1);
      pcm_width = 5'd31; run_frames(1);
      pcm_width = 5'd1; pcm_left = 20'h00001; pcm_right = 20'hFFFFE; run_frames(1);
      // R7: mono duplicates left
      pcm_width = 5'd16; mono = 1'b1; pcm_left = 20'h0BEEF; pcm_right = 20'h01234;
      run_frames(1);
      // R8: partial and empty valid sets, spare slot flagged
      mono = 1'b0; slot_valid = 12'b0000_0100_1010; run_frames(1);
      slot_valid = 12'h000; run_frames(1);
      // R9: inputs changed mid-frame only affect later frames
      scen_req = "R9";
      for (int i = 0; i < 4; i++) begin
         repeat (37 + 61 * i) @(negedge clk);
         slot_valid = 12'hFFF ^ (12'h5 << i); cmd_rd = i[0];
         cmd_idx = 7'(9 * i + 3); cmd_wdata = 16'(16'h1357 * (i + 1));
         pcm_left = 20'(20'h1F2E3 + i); pcm_right = 20'(20'hC0FFE - i);
         pcm_width = 5'(12 + i * 3); mono = i[1];
      end
      run_frames(2);
      scen_req = "";
      finish_run();
   end
endmodule